// File: doc/BRIEF.md
# Split egress/ingress buffer

This block joins a system-side word port and a serial-engine port to two buffer regions with fixed directions. The system fills the egress region, and the serial engine reads it back one word at a time. The serial engine fills the ingress region, and the system reads it. The system sees each region as its own window in a byte-addressed space. The block checks every system access against the window's direction, its alignment and its byte enables. It answers each system request exactly one cycle later, with either data or an error flag.

The serial engine writes ingress bytes in pieces. Each ingress word therefore carries a "written since reset" flag. The first sub-word write to a word clears the bytes it does not carry, so every stored word has consistent parity from then on. Each byte lane stores an odd-parity bit, and a system read that meets a bad lane returns an error. A parameter selects the storage arrangement: two one-read-one-write memories, or one shared two-port memory. The behaviour at the ports is the same in both arrangements.

Top module: `dbuf_top`

## Requirements
- R1: The system address is a byte address. The egress window covers 0x1000 to 0x1CFC (832 words), and the ingress window covers 0x1E00 to 0x1F7C (96 words). Any address outside both windows, or with a nonzero value in bits [1:0], returns an error and changes no memory.
- R2: A system write with sys_be = 4'hF to an egress address stores the word at local index (addr-0x1000)/4. A later serial read of that index returns the word on spi_rdata, with spi_rvalid high one cycle after the read request.
- R3: A system write whose sys_be is not 4'hF returns an error and leaves the addressed word unchanged.
- R4: A system read of an egress address returns an error with sys_rdata equal to zero.
- R5: A system write to an ingress address returns an error and leaves the ingress word unchanged.
- R6: A serial write to ingress local index i makes the word readable by the system at 0x1E00+4*i, with no error.
- R7: The first serial write since reset to an ingress word stores the enabled bytes and sets the other bytes to zero. Later serial writes to that word change only the bytes whose spi_be bit is set. A write with spi_be = 0 does nothing.
- R8: A system read of an ingress word that no serial write has touched since reset returns an error with zero data.
- R9: Each byte lane has an odd-parity bit. On a serial write, bit k of spi_par_flip inverts the stored parity of lane k, but only if lane k is enabled. A system read of a word with any bad lane returns an error with zero data. Rewriting the lane with the flip bit clear repairs it.
- R10: sys_rvalid is high exactly in the cycle after each sys_req. sys_err and sys_rdata are valid in that cycle and are zero in every other cycle.
- R11: The two storage arrangements (SPLIT_RAMS = 1 and SPLIT_RAMS = 0) give identical port behaviour.
- R12: A serial write to an ingress index of 96 or more changes no memory. A serial read of an egress index of 832 or more returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_req | input | 1 | System request strobe |
| sys_we | input | 1 | System write (1) or read (0) |
| sys_addr | input | 13 | System byte address |
| sys_be | input | 4 | System byte enables |
| sys_wdata | input | 32 | System write data |
| sys_rvalid | output | 1 | Response valid, one cycle after the request |
| sys_rdata | output | 32 | System read data |
| sys_err | output | 1 | System error response |
| spi_req | input | 1 | Serial-engine request strobe |
| spi_we | input | 1 | Serial write to ingress (1) or read of egress (0) |
| spi_idx | input | 10 | Word index local to the region |
| spi_wdata | input | 32 | Serial write data |
| spi_be | input | 4 | Serial byte enables |
| spi_par_flip | input | 4 | Per-lane parity inversion on serial writes |
| spi_rvalid | output | 1 | Serial read data valid |
| spi_rdata | output | 32 | Serial read data from egress |

## Verification
The bench probes both edges of each window and the gap between the windows. A decoder with an off-by-one bound would accept an unmapped word or reject the last word of a window. It tries partial system writes and writes into the read-only window, then reads the target back through the other port, so a design that wrote anyway is caught by the changed data. Sub-word serial writes to fresh ingress words expose a design that left stale bytes or overwrote bytes it should keep. A large serial index exposes a shared-memory design that lets the address wrap into egress. Parity flips on enabled and disabled lanes show whether the error check and its repair path look at the right lanes.

// File: rtl/dbuf_pkg.sv
`timescale 1ns/1ps
package dbuf_pkg;
  localparam int LANES   = 4;
  localparam int BYTE_W  = 8;
  localparam int LANE_W  = BYTE_W + 1;
  localparam int WORD_W  = LANES * BYTE_W;
  localparam int ENTRY_W = LANES * LANE_W;

  // Build a stored entry: per lane {parity, byte}, odd parity, optional inversion
  function automatic logic [ENTRY_W-1:0] pack_entry(input logic [WORD_W-1:0] d,
                                                    input logic [LANES-1:0] flip);
    logic [ENTRY_W-1:0] e;
    for (int k = 0; k < LANES; k++) begin
      e[k*LANE_W +: LANE_W] = {(~^d[k*BYTE_W +: BYTE_W]) ^ flip[k], d[k*BYTE_W +: BYTE_W]};
    end
    return e;
  endfunction

  function automatic logic [WORD_W-1:0] entry_data(input logic [ENTRY_W-1:0] e);
    logic [WORD_W-1:0] d;
    for (int k = 0; k < LANES; k++) begin
      d[k*BYTE_W +: BYTE_W] = e[k*LANE_W +: BYTE_W];
    end
    return d;
  endfunction

  // A lane is bad when its nine bits hold an even number of ones
  function automatic logic [LANES-1:0] entry_bad(input logic [ENTRY_W-1:0] e);
    logic [LANES-1:0] b;
    for (int k = 0; k < LANES; k++) begin
      b[k] = ~(^e[k*LANE_W +: LANE_W]);
    end
    return b;
  endfunction
endpackage

// File: rtl/dbuf_sys_decode.sv
`timescale 1ns/1ps
module dbuf_sys_decode #(
  parameter int AW        = 13,
  parameter int IW        = 10,
  parameter int EGR_BASE  = 'h1000,
  parameter int EGR_WORDS = 832,
  parameter int ING_BASE  = 'h1E00,
  parameter int ING_WORDS = 96
) (
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [3:0]    be,
  output logic          wr_ok,
  output logic          rd_try,
  output logic [IW-1:0] idx
);
  localparam int WA = AW - 2;
  localparam logic [WA-1:0] E_LO = WA'(EGR_BASE / 4);
  localparam logic [WA-1:0] E_HI = WA'(EGR_BASE / 4 + EGR_WORDS - 1);
  localparam logic [WA-1:0] I_LO = WA'(ING_BASE / 4);
  localparam logic [WA-1:0] I_HI = WA'(ING_BASE / 4 + ING_WORDS - 1);

  logic [WA-1:0] word;
  logic aligned, in_egr, in_ing;

  always_comb begin
    word    = addr[AW-1:2];
    aligned = (addr[1:0] == 2'b00);
    in_egr  = (word >= E_LO) && (word <= E_HI);
    in_ing  = (word >= I_LO) && (word <= I_HI);
    idx     = in_egr ? IW'(word - E_LO) : IW'(word - I_LO);
    wr_ok   = we && in_egr && aligned && (be == 4'hF);
    rd_try  = !we && in_ing && aligned;
  end
endmodule

// File: rtl/dbuf_ing_fill.sv
`timescale 1ns/1ps
module dbuf_ing_fill import dbuf_pkg::*; #(
  parameter int ING_WORDS = 96,
  parameter int IW        = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IW-1:0]      idx,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [LANES-1:0]   be,
  input  logic [LANES-1:0]   flip,
  input  logic               rd_en,
  input  logic [IW-1:0]      rd_idx,
  output logic               wr_en,
  output logic [LANES-1:0]   wr_lanes,
  output logic [ENTRY_W-1:0] wr_entry,
  output logic               rd_filled
);
  localparam logic [IW-1:0] LAST = IW'(ING_WORDS - 1);

  logic [ING_WORDS-1:0] filled;
  logic                 in_range, first;
  logic [WORD_W-1:0]    merged;

  always_comb begin
    in_range = (idx <= LAST);
    first    = in_range ? !filled[idx] : 1'b0;
    wr_en    = we && in_range && (be != '0);
    for (int k = 0; k < LANES; k++) begin
      merged[k*BYTE_W +: BYTE_W] = be[k] ? wdata[k*BYTE_W +: BYTE_W] : '0;
    end
    wr_entry = pack_entry(merged, flip & be);
    wr_lanes = first ? '1 : be;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filled    <= '0;
      rd_filled <= 1'b0;
    end else begin
      if (wr_en) filled[idx] <= 1'b1;
      if (rd_en) rd_filled <= (rd_idx <= LAST) ? filled[rd_idx] : 1'b0;
    end
  end

  // R7
  first_write_marks_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> filled[$past(idx)]);
endmodule

// File: rtl/dbuf_ram1r1w.sv
`timescale 1ns/1ps
module dbuf_ram1r1w import dbuf_pkg::*; #(
  parameter int DEPTH = 96,
  parameter int AW    = 10
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [LANES-1:0]   lane_we,
  input  logic               re,
  input  logic [AW-1:0]      raddr,
  output logic [ENTRY_W-1:0] q
);
  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < LANES; k++) begin
        if (lane_we[k]) mem[waddr][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
      end
    end
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/dbuf_ram2p.sv
`timescale 1ns/1ps
module dbuf_ram2p import dbuf_pkg::*; #(
  parameter int DEPTH = 928,
  parameter int AW    = 10
) (
  input  logic               clk,
  input  logic               a_en,
  input  logic               a_we,
  input  logic [AW-1:0]      a_addr,
  input  logic [ENTRY_W-1:0] a_wdata,
  input  logic [LANES-1:0]   a_lane_we,
  output logic [ENTRY_W-1:0] a_q,
  input  logic               b_en,
  input  logic               b_we,
  input  logic [AW-1:0]      b_addr,
  input  logic [ENTRY_W-1:0] b_wdata,
  input  logic [LANES-1:0]   b_lane_we,
  output logic [ENTRY_W-1:0] b_q
);
  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (a_en && a_we && a_lane_we[k]) mem[a_addr][k*LANE_W +: LANE_W] <= a_wdata[k*LANE_W +: LANE_W];
      if (b_en && b_we && b_lane_we[k]) mem[b_addr][k*LANE_W +: LANE_W] <= b_wdata[k*LANE_W +: LANE_W];
    end
    if (a_en && !a_we) a_q <= mem[a_addr];
    if (b_en && !b_we) b_q <= mem[b_addr];
  end
endmodule

// File: rtl/dbuf_store.sv
`timescale 1ns/1ps
module dbuf_store import dbuf_pkg::*; #(
  parameter int EGR_WORDS  = 832,
  parameter int ING_WORDS  = 96,
  parameter int IW         = 10,
  parameter bit SPLIT_RAMS = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  // system side: writes egress, reads ingress
  input  logic               a_en,
  input  logic               a_we,
  input  logic [IW-1:0]      a_idx,
  input  logic [ENTRY_W-1:0] a_wdata,
  output logic [ENTRY_W-1:0] a_q,
  // serial side: reads egress, writes ingress
  input  logic               b_en,
  input  logic               b_we,
  input  logic [IW-1:0]      b_idx,
  input  logic [ENTRY_W-1:0] b_wdata,
  input  logic [LANES-1:0]   b_lane_we,
  output logic [ENTRY_W-1:0] b_q
);
  localparam logic [IW-1:0] EGR_LAST = IW'(EGR_WORDS - 1);
  localparam logic [IW-1:0] ING_LAST = IW'(ING_WORDS - 1);

  logic               a_ok, b_ok, b_ok_q;
  logic               a_go, b_go;
  logic [ENTRY_W-1:0] b_raw;

  always_comb begin
    a_ok = a_we ? (a_idx <= EGR_LAST) : (a_idx <= ING_LAST);
    b_ok = b_we ? (b_idx <= ING_LAST) : (b_idx <= EGR_LAST);
    a_go = a_en && a_ok;
    b_go = b_en && b_ok;
    b_q  = b_ok_q ? b_raw : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                b_ok_q <= 1'b0;
    else if (b_en && !b_we) b_ok_q <= b_ok;
  end

  generate
    if (SPLIT_RAMS) begin : g_split
      dbuf_ram1r1w #(.DEPTH(EGR_WORDS), .AW(IW)) u_egr (
        .clk(clk), .we(a_go && a_we), .waddr(a_idx), .wdata(a_wdata), .lane_we('1),
        .re(b_go && !b_we), .raddr(b_idx), .q(b_raw));
      dbuf_ram1r1w #(.DEPTH(ING_WORDS), .AW(IW)) u_ing (
        .clk(clk), .we(b_go && b_we), .waddr(b_idx), .wdata(b_wdata), .lane_we(b_lane_we),
        .re(a_go && !a_we), .raddr(a_idx), .q(a_q));
    end else begin : g_shared
      localparam int DEPTH = EGR_WORDS + ING_WORDS;
      localparam int MAW   = $clog2(DEPTH);
      localparam logic [MAW-1:0] ING_OFS = MAW'(EGR_WORDS);
      logic [MAW-1:0] a_addr, b_addr;
      always_comb begin
        a_addr = a_we ? MAW'(a_idx) : MAW'(a_idx) + ING_OFS;
        b_addr = b_we ? MAW'(b_idx) + ING_OFS : MAW'(b_idx);
      end
      dbuf_ram2p #(.DEPTH(DEPTH), .AW(MAW)) u_mem (
        .clk(clk),
        .a_en(a_go), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_lane_we('1), .a_q(a_q),
        .b_en(b_go), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_lane_we(b_lane_we),
        .b_q(b_raw));
    end
  endgenerate
endmodule

// File: rtl/dbuf_top.sv
`timescale 1ns/1ps
module dbuf_top import dbuf_pkg::*; #(
  parameter int SYS_AW     = 13,
  parameter int EGR_BASE   = 'h1000,
  parameter int EGR_WORDS  = 832,
  parameter int ING_BASE   = 'h1E00,
  parameter int ING_WORDS  = 96,
  parameter bit SPLIT_RAMS = 1'b1,
  parameter int IDX_W      = $clog2(EGR_WORDS > ING_WORDS ? EGR_WORDS : ING_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_req,
  input  logic              sys_we,
  input  logic [SYS_AW-1:0] sys_addr,
  input  logic [3:0]        sys_be,
  input  logic [31:0]       sys_wdata,
  output logic              sys_rvalid,
  output logic [31:0]       sys_rdata,
  output logic              sys_err,
  input  logic              spi_req,
  input  logic              spi_we,
  input  logic [IDX_W-1:0]  spi_idx,
  input  logic [31:0]       spi_wdata,
  input  logic [3:0]        spi_be,
  input  logic [3:0]        spi_par_flip,
  output logic              spi_rvalid,
  output logic [31:0]       spi_rdata
);
  logic               wr_ok, rd_try;
  logic [IDX_W-1:0]   sys_idx;
  logic               a_en, a_we;
  logic [ENTRY_W-1:0] a_wdata, a_q, b_q;
  logic               fill_wr, rd_filled;
  logic [LANES-1:0]   fill_lanes;
  logic [ENTRY_W-1:0] fill_entry;
  logic               b_en, b_we;
  logic               rsp_vld, rsp_rd, rsp_bad, spi_vld;
  logic               rd_fail;

  dbuf_sys_decode #(
    .AW(SYS_AW), .IW(IDX_W), .EGR_BASE(EGR_BASE), .EGR_WORDS(EGR_WORDS),
    .ING_BASE(ING_BASE), .ING_WORDS(ING_WORDS)
  ) u_dec (
    .addr(sys_addr), .we(sys_we), .be(sys_be), .wr_ok(wr_ok), .rd_try(rd_try), .idx(sys_idx));

  dbuf_ing_fill #(.ING_WORDS(ING_WORDS), .IW(IDX_W)) u_fill (
    .clk(clk), .rst(rst),
    .we(spi_req && spi_we), .idx(spi_idx), .wdata(spi_wdata), .be(spi_be), .flip(spi_par_flip),
    .rd_en(sys_req && rd_try), .rd_idx(sys_idx),
    .wr_en(fill_wr), .wr_lanes(fill_lanes), .wr_entry(fill_entry), .rd_filled(rd_filled));

  always_comb begin
    a_en    = sys_req && (wr_ok || rd_try);
    a_we    = sys_req && wr_ok;
    a_wdata = pack_entry(sys_wdata, '0);
    b_we    = spi_req && spi_we;
    b_en    = spi_req && (spi_we ? fill_wr : 1'b1);
  end

  dbuf_store #(
    .EGR_WORDS(EGR_WORDS), .ING_WORDS(ING_WORDS), .IW(IDX_W), .SPLIT_RAMS(SPLIT_RAMS)
  ) u_store (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_idx(sys_idx), .a_wdata(a_wdata), .a_q(a_q),
    .b_en(b_en), .b_we(b_we), .b_idx(spi_idx), .b_wdata(fill_entry), .b_lane_we(fill_lanes),
    .b_q(b_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld <= 1'b0;
      rsp_rd  <= 1'b0;
      rsp_bad <= 1'b0;
      spi_vld <= 1'b0;
    end else begin
      rsp_vld <= sys_req;
      rsp_rd  <= sys_req && rd_try;
      rsp_bad <= sys_req && !wr_ok && !rd_try;
      spi_vld <= spi_req && !spi_we;
    end
  end

  always_comb begin
    rd_fail    = rsp_rd && (!rd_filled || (entry_bad(a_q) != '0));
    sys_rvalid = rsp_vld;
    sys_err    = rsp_bad || rd_fail;
    sys_rdata  = (rsp_rd && !rd_fail) ? entry_data(a_q) : '0;
    spi_rvalid = spi_vld;
    spi_rdata  = spi_vld ? entry_data(b_q) : '0;
  end

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    sys_req |=> sys_rvalid);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sys_rvalid |-> (!sys_err && sys_rdata == '0));
  // R4
  err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    sys_err |-> (sys_rdata == '0));
  // R3
  full_word_write_chk: assert property (@(posedge clk) disable iff (rst)
    a_we |-> (sys_be == 4'hF && sys_we));
  // R2
  spi_rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_req && !spi_we) |=> spi_rvalid);
endmodule

// File: tb/dbuf_top_tb.sv
`timescale 1ns/1ps
module dbuf_top_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst;
  logic        sys_req, sys_we;
  logic [12:0] sys_addr;
  logic [3:0]  sys_be;
  logic [31:0] sys_wdata;
  logic        spi_req, spi_we;
  logic [9:0]  spi_idx;
  logic [31:0] spi_wdata;
  logic [3:0]  spi_be, spi_par_flip;

  logic        rv_a, err_a, srv_a, rv_b, err_b, srv_b;
  logic [31:0] rd_a, srd_a, rd_b, srd_b;

  dbuf_top #(.SPLIT_RAMS(1'b1)) u_dut (
    .clk(clk), .rst(rst), .sys_req(sys_req), .sys_we(sys_we), .sys_addr(sys_addr),
    .sys_be(sys_be), .sys_wdata(sys_wdata), .sys_rvalid(rv_a), .sys_rdata(rd_a), .sys_err(err_a),
    .spi_req(spi_req), .spi_we(spi_we), .spi_idx(spi_idx), .spi_wdata(spi_wdata),
    .spi_be(spi_be), .spi_par_flip(spi_par_flip), .spi_rvalid(srv_a), .spi_rdata(srd_a));

  dbuf_top #(.SPLIT_RAMS(1'b0)) u_dut_2p (
    .clk(clk), .rst(rst), .sys_req(sys_req), .sys_we(sys_we), .sys_addr(sys_addr),
    .sys_be(sys_be), .sys_wdata(sys_wdata), .sys_rvalid(rv_b), .sys_rdata(rd_b), .sys_err(err_b),
    .spi_req(spi_req), .spi_we(spi_we), .spi_idx(spi_idx), .spi_wdata(spi_wdata),
    .spi_be(spi_be), .spi_par_flip(spi_par_flip), .spi_rvalid(srv_b), .spi_rdata(srd_b));

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] egr_m [832];
  logic [31:0] ing_m [96];
  logic        ing_v [96];
  logic [3:0]  ing_bad [96];

  logic [32:0] sys_q [$];
  string       sys_tag [$];
  logic [31:0] spi_q [$];
  string       spi_tag [$];

  task automatic check(string tag, string what, logic [32:0] got, logic [32:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  function automatic bit in_egr(logic [12:0] a);
    return a >= 13'h1000 && a <= 13'h1CFF;
  endfunction
  function automatic bit in_ing(logic [12:0] a);
    return a >= 13'h1E00 && a <= 13'h1F7F;
  endfunction

  task automatic sys_write(logic [12:0] a, logic [3:0] be, logic [31:0] d, string tag);
    bit ok;
    @(negedge clk);
    sys_req = 1; sys_we = 1; sys_addr = a; sys_be = be; sys_wdata = d;
    ok = in_egr(a) && a[1:0] == 0 && be == 4'hF;
    if (ok) egr_m[(a - 13'h1000) >> 2] = d;
    sys_q.push_back({!ok, 32'h0});
    sys_tag.push_back(tag);
    @(negedge clk);
    sys_req = 0;
  endtask

  function automatic logic [32:0] exp_read(logic [12:0] a);
    int i;
    if (!(in_ing(a) && a[1:0] == 0)) return {1'b1, 32'h0};
    i = (a - 13'h1E00) >> 2;
    if (!ing_v[i] || ing_bad[i] != 0) return {1'b1, 32'h0};
    return {1'b0, ing_m[i]};
  endfunction

  task automatic sys_read(logic [12:0] a, string tag);
    @(negedge clk);
    sys_req = 1; sys_we = 0; sys_addr = a; sys_be = 4'hF; sys_wdata = 0;
    sys_q.push_back(exp_read(a));
    sys_tag.push_back(tag);
    @(negedge clk);
    sys_req = 0;
  endtask

  task automatic spi_write(int idx, logic [3:0] be, logic [31:0] d, logic [3:0] flip);
    @(negedge clk);
    spi_req = 1; spi_we = 1; spi_idx = 10'(idx); spi_be = be; spi_wdata = d; spi_par_flip = flip;
    if (idx < 96 && be != 0) begin
      if (!ing_v[idx]) begin
        ing_m[idx] = 0; ing_bad[idx] = 0; ing_v[idx] = 1;
      end
      for (int k = 0; k < 4; k++) begin
        if (be[k]) begin
          ing_m[idx][k*8 +: 8] = d[k*8 +: 8];
          ing_bad[idx][k] = flip[k];
        end
      end
    end
    @(negedge clk);
    spi_req = 0; spi_par_flip = 0;
  endtask

  task automatic spi_read(int idx, string tag);
    @(negedge clk);
    spi_req = 1; spi_we = 0; spi_idx = 10'(idx);
    spi_q.push_back(idx < 832 ? egr_m[idx] : 32'h0);
    spi_tag.push_back(tag);
    @(negedge clk);
    spi_req = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rv_a) begin
        if (sys_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R10 unexpected response got=1 exp=0");
        end else begin
          logic [32:0] e;
          string t;
          e = sys_q.pop_front();
          t = sys_tag.pop_front();
          check(t, "sys {err,rdata}", {err_a, rd_a}, e);
          check("R11", "2p sys {valid,err,rdata}", {rv_b, err_b, rd_b}, {1'b1, e});
        end
      end else begin
        check("R10", "idle {valid2p,err,rdata}", {rv_b, err_a, rd_a}, 33'h0);
      end
      if (srv_a) begin
        if (spi_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R2 unexpected spi data got=1 exp=0");
        end else begin
          logic [31:0] e;
          string t;
          e = spi_q.pop_front();
          t = spi_tag.pop_front();
          check(t, "spi rdata", {1'b0, srd_a}, {1'b0, e});
          check("R11", "2p spi {valid,rdata}", {srv_b, srd_b}, {1'b1, e});
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 96; i++) begin ing_v[i] = 0; ing_bad[i] = 0; ing_m[i] = 0; end
    for (int i = 0; i < 832; i++) egr_m[i] = 0;
    rst = 1; sys_req = 0; sys_we = 0; sys_addr = 0; sys_be = 0; sys_wdata = 0;
    spi_req = 0; spi_we = 0; spi_idx = 0; spi_wdata = 0; spi_be = 0; spi_par_flip = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "reset outputs", {rv_a, err_a, rd_a}, 33'h0);
    check("R10", "reset spi outputs", {srv_a, srd_a}, 33'h0);
    rst = 0;

    // R8: untouched ingress words
    sys_read(13'h1E00, "R8");
    sys_read(13'h1F7C, "R8");

    // R2: egress writes at both edges and middle
    sys_write(13'h1000, 4'hF, 32'hA1B2C3D4, "R2");
    sys_write(13'h1CFC, 4'hF, 32'h0BADF00D, "R2");
    sys_write(13'h1800, 4'hF, 32'h12345678, "R2");
    sys_write(13'h1004, 4'hF, 32'hCAFE0001, "R2");
    sys_write(13'h1020, 4'hF, 32'h55AA55AA, "R2");
    spi_read(0, "R2");
    spi_read(831, "R2");
    spi_read(512, "R2");

    // R4: egress not readable
    sys_read(13'h1000, "R4");
    sys_read(13'h1CFC, "R4");

    // R3: partial write rejected, word kept
    sys_write(13'h1004, 4'h3, 32'hFFFFFFFF, "R3");
    sys_write(13'h1004, 4'h0, 32'hEEEEEEEE, "R3");
    spi_read(1, "R3");

    // R1: unmapped and misaligned
    sys_write(13'h0FFC, 4'hF, 32'h1, "R1");
    sys_write(13'h1D00, 4'hF, 32'h2, "R1");
    sys_write(13'h1002, 4'hF, 32'h3, "R1");
    sys_read(13'h1F80, "R1");
    sys_read(13'h0000, "R1");
    spi_read(0, "R1");

    // R6: serial ingress writes visible to system
    spi_write(0, 4'hF, 32'hDEADBEEF, 4'h0);
    spi_write(95, 4'hF, 32'h87654321, 4'h0);
    sys_read(13'h1E00, "R6");
    sys_read(13'h1F7C, "R6");
    sys_read(13'h1E02, "R1");

    // R5: system write to ingress rejected
    sys_write(13'h1E00, 4'hF, 32'h0, "R5");
    sys_read(13'h1E00, "R5");

    // R7: first partial write zero-fills, later keeps
    spi_write(5, 4'h2, 32'hAABBCCDD, 4'h0);
    sys_read(13'h1E14, "R7");
    spi_write(5, 4'h8, 32'h11223344, 4'h0);
    sys_read(13'h1E14, "R7");
    spi_write(5, 4'h0, 32'hFFFFFFFF, 4'h0);
    sys_read(13'h1E14, "R7");

    // R9: parity injection and repair
    spi_write(7, 4'hF, 32'h0F0F0F0F, 4'h4);
    sys_read(13'h1E1C, "R9");
    spi_write(7, 4'h4, 32'h00990000, 4'h0);
    sys_read(13'h1E1C, "R9");
    spi_write(8, 4'h1, 32'h000000AB, 4'h2);
    sys_read(13'h1E20, "R9");
    spi_write(9, 4'h3, 32'h0000ABCD, 4'h1);
    sys_read(13'h1E24, "R9");

    // R12: out-of-range serial accesses
    spi_write(200, 4'hF, 32'hFFFF0000, 4'h0);
    spi_write(96, 4'hF, 32'h77777777, 4'h0);
    spi_read(8, "R12");
    spi_read(832, "R12");
    spi_read(900, "R12");
    sys_read(13'h1E00, "R12");

    // R10: back-to-back requests
    @(negedge clk);
    sys_req = 1; sys_we = 0; sys_addr = 13'h1F7C; sys_be = 4'hF;
    sys_q.push_back(exp_read(13'h1F7C)); sys_tag.push_back("R10");
    @(negedge clk);
    sys_addr = 13'h1000;
    sys_q.push_back(exp_read(13'h1000)); sys_tag.push_back("R10");
    @(negedge clk);
    sys_req = 0;

    repeat (4) @(negedge clk);
    check("R10", "pending responses", 33'(sys_q.size() + spi_q.size()), 33'h0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule